// File: doc/BRIEF.md
# Write Window Block Mark Tracker

This block records, for every block of the currently open write window, whether the host has changed it (dirty) or asked for it to be wiped (erased). The host's mark commands give a start block and a block count, both relative to the first block of the window. The tracker checks each request against the window size and either applies it or rejects it. A rejected request changes nothing.

On a flush request the tracker visits the marked blocks in ascending order. For each one it presents a single writeback request, which names the block and says whether the block must be programmed or only erased. A block is unmarked once its request is accepted. When no marked block remains, the tracker signals completion.

The tracker also sits on the read path. Any byte read from a block that is currently marked erased is replaced by 0xFF. Opening or closing a window throws away all marks. The block data itself is stored elsewhere.

Top module: `wwin_tracker`

## Requirements
- R1: After reset, no block is marked, mark_ack, wb_valid and flush_done are low, and rd_data_out equals rd_data_in.
- R2: A mark request (mark_valid high for one cycle) on an open window with mark_off + mark_cnt <= the window size, and no flush running, is answered in the next cycle by mark_ack=1 with mark_ok=1. It sets blocks mark_off through mark_off+mark_cnt-1 to erased when mark_erase=1, or to dirty when mark_erase=0.
- R3: A mark request whose mark_off + mark_cnt exceeds the window size is answered by mark_ack=1 with mark_ok=0 and leaves every mark unchanged. A window opened with size zero rejects every request.
- R4: The latest accepted mark on a block decides its state. Erased and then dirty gives dirty; dirty and then erased gives erased.
- R5: While rd_block names a block marked erased, rd_data_out is 8'hFF. Otherwise it equals rd_data_in.
- R6: After flush_start, one writeback request is issued for each marked block, in ascending block order. Each request drives wb_index to the block number and wb_erase to 1 for an erased block (erase only) or to 0 for a dirty block (the backing side erases, then programs). The request stays stable until a cycle in which wb_ready is high.
- R7: flush_done is a one-cycle pulse that comes after every writeback has been accepted, and it leaves all blocks unmarked. A flush with nothing marked issues no writeback and pulses flush_done within two cycles.
- R8: win_open (which loads win_blocks as the window size) and win_close each discard all marks and abandon any flush in progress.
- R9: Mark requests made while no window is open, or while a flush is running, are rejected (mark_ok=0) and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| win_open | input | 1 | Open a window, load its size |
| win_close | input | 1 | Close the window |
| win_blocks | input | CW | Window size in blocks |
| mark_valid | input | 1 | Mark request strobe |
| mark_erase | input | 1 | 1 = mark erased, 0 = mark dirty |
| mark_off | input | CW | First block, relative to window start |
| mark_cnt | input | CW | Number of blocks |
| mark_ack | output | 1 | Mark request answered |
| mark_ok | output | 1 | Request applied (valid with mark_ack) |
| flush_start | input | 1 | Begin flush |
| flush_done | output | 1 | Flush finished pulse |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_index | output | IW | Block of the writeback |
| wb_erase | output | 1 | 1 = erase only, 0 = program |
| rd_block | input | IW | Block being read |
| rd_data_in | input | 8 | Stored read byte |
| rd_data_out | output | 8 | Byte returned to the host |

## Verification
On every cycle the assertions check that:
- a pending writeback holds steady until it is accepted;
- each writeback's kind matches the mark held by the block it names;
- a closed window leaves no mark behind;
- a rejected request leaves the mark vectors untouched;
- flush_done lasts a single cycle.

Other behaviours can only be shown by the bench's scenarios. These are the ascending order of the writebacks, which mark wins when marks overlap, the exact boundary where offset plus count meets the window size, and the 0xFF substitution as seen from the read port.

// File: rtl/wwin_pkg.sv
package wwin_pkg;
    typedef enum logic [1:0] {MK_CLEAN, MK_DIRTY, MK_ERASED} mark_e;
    typedef enum logic {FL_IDLE, FL_WALK} flush_e;
endpackage

// File: rtl/wwin_range_chk.sv
module wwin_range_chk #(
    parameter int CW = 5
) (
    input  logic          is_open,
    input  logic [CW-1:0] size,
    input  logic [CW-1:0] off,
    input  logic [CW-1:0] cnt,
    output logic          fits
);
    logic [CW:0] end_blk;
    always_comb begin
        end_blk = {1'b0, off} + {1'b0, cnt};
        fits    = is_open && (size != '0) && (end_blk <= {1'b0, size});
    end
endmodule

// File: rtl/wwin_mark_store.sv
module wwin_mark_store
    import wwin_pkg::*;
#(
    parameter int NBLK = 16,
    parameter int CW   = $clog2(NBLK) + 1,
    parameter int IW   = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic            set_en,
    input  logic            set_erase,
    input  logic [CW-1:0]   set_off,
    input  logic [CW-1:0]   set_cnt,
    input  logic            drop_en,
    input  logic [IW-1:0]   drop_idx,
    output logic [NBLK-1:0] dirty_vec,
    output logic [NBLK-1:0] erased_vec
);
    typedef struct {
        mark_e m [NBLK];
    } store_t;

    store_t st_d, st_q;
    logic [CW:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = {1'b0, set_off} + {1'b0, set_cnt};
        for (int i = 0; i < NBLK; i++) begin
            if (clr_all) begin
                st_d.m[i] = MK_CLEAN;
            end else begin
                if (drop_en && (drop_idx == IW'(i)))
                    st_d.m[i] = MK_CLEAN;
                if (set_en && ((CW+1)'(i) >= {1'b0, set_off}) && ((CW+1)'(i) < lim))
                    st_d.m[i] = set_erase ? MK_ERASED : MK_DIRTY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) st_q.m[i] <= MK_CLEAN;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_vec
        assign dirty_vec[g]  = (st_q.m[g] == MK_DIRTY);
        assign erased_vec[g] = (st_q.m[g] == MK_ERASED);
    end
endmodule

// File: rtl/wwin_flush_seq.sv
module wwin_flush_seq
    import wwin_pkg::*;
#(
    parameter int NBLK = 16,
    parameter int IW   = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            start,
    input  logic [NBLK-1:0] dirty_vec,
    input  logic [NBLK-1:0] erased_vec,
    input  logic            wb_ready,
    output logic            wb_valid,
    output logic [IW-1:0]   wb_index,
    output logic            wb_erase,
    output logic            busy,
    output logic            done,
    output logic            drop_en,
    output logic [IW-1:0]   drop_idx
);
    typedef struct packed {
        flush_e st;
        logic   done;
    } seq_t;

    seq_t s_d, s_q;
    logic [NBLK-1:0] pend;
    logic [IW-1:0]   low;

    always_comb begin
        pend = dirty_vec | erased_vec;
        low  = '0;
        for (int i = NBLK - 1; i >= 0; i--)
            if (pend[i]) low = IW'(i);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        wb_valid = 1'b0;
        drop_en  = 1'b0;
        if (abort) begin
            s_d.st = FL_IDLE;
        end else if (s_q.st == FL_IDLE) begin
            if (start) s_d.st = FL_WALK;
        end else if (|pend) begin
            wb_valid = 1'b1;
            drop_en  = wb_ready;
        end else begin
            s_d.done = 1'b1;
            s_d.st   = FL_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: FL_IDLE, done: 1'b0};
        else        s_q <= s_d;
    end

    assign wb_index = low;
    assign wb_erase = erased_vec[low];
    assign drop_idx = low;
    assign busy     = (s_q.st == FL_WALK);
    assign done     = s_q.done;
endmodule

// File: rtl/wwin_tracker.sv
module wwin_tracker #(
    parameter int NBLK = 16,
    parameter int IW   = $clog2(NBLK),
    parameter int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_open,
    input  logic          win_close,
    input  logic [CW-1:0] win_blocks,
    input  logic          mark_valid,
    input  logic          mark_erase,
    input  logic [CW-1:0] mark_off,
    input  logic [CW-1:0] mark_cnt,
    output logic          mark_ack,
    output logic          mark_ok,
    input  logic          flush_start,
    output logic          flush_done,
    output logic          wb_valid,
    input  logic          wb_ready,
    output logic [IW-1:0] wb_index,
    output logic          wb_erase,
    input  logic [IW-1:0] rd_block,
    input  logic [7:0]    rd_data_in,
    output logic [7:0]    rd_data_out
);
    typedef struct packed {
        logic [CW-1:0] size;
        logic          open;
        logic          ack;
        logic          ok;
    } top_t;

    top_t t_d, t_q;
    logic fits, take, clr_all, busy, drop_en;
    logic [IW-1:0]   drop_idx;
    logic [NBLK-1:0] dirty_vec, erased_vec;

    assign clr_all = win_open | win_close;

    wwin_range_chk #(.CW(CW)) rng_i (
        .is_open(t_q.open), .size(t_q.size), .off(mark_off), .cnt(mark_cnt), .fits(fits)
    );

    assign take = mark_valid && fits && !busy && !clr_all;

    wwin_mark_store #(.NBLK(NBLK), .CW(CW), .IW(IW)) store_i (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .set_en(take), .set_erase(mark_erase), .set_off(mark_off), .set_cnt(mark_cnt),
        .drop_en(drop_en), .drop_idx(drop_idx),
        .dirty_vec(dirty_vec), .erased_vec(erased_vec)
    );

    wwin_flush_seq #(.NBLK(NBLK), .IW(IW)) seq_i (
        .clk(clk), .rst_n(rst_n), .abort(clr_all), .start(flush_start),
        .dirty_vec(dirty_vec), .erased_vec(erased_vec), .wb_ready(wb_ready),
        .wb_valid(wb_valid), .wb_index(wb_index), .wb_erase(wb_erase),
        .busy(busy), .done(flush_done), .drop_en(drop_en), .drop_idx(drop_idx)
    );

    always_comb begin
        t_d     = t_q;
        t_d.ack = mark_valid;
        t_d.ok  = take;
        if (win_open) begin
            t_d.open = 1'b1;
            t_d.size = win_blocks;
        end else if (win_close) begin
            t_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign mark_ack    = t_q.ack;
    assign mark_ok     = t_q.ok;
    assign rd_data_out = erased_vec[rd_block] ? 8'hFF : rd_data_in;
endmodule

// File: rtl/wwin_tracker_chk.sv
module wwin_tracker_chk #(
    parameter int NBLK = 16,
    parameter int IW   = $clog2(NBLK)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            win_open,
    input logic            win_close,
    input logic            mark_ack,
    input logic            mark_ok,
    input logic            flush_done,
    input logic            wb_valid,
    input logic            wb_ready,
    input logic [IW-1:0]   wb_index,
    input logic            wb_erase,
    input logic            busy,
    input logic [NBLK-1:0] dirty_vec,
    input logic [NBLK-1:0] erased_vec
);
    // R6: request held until accepted
    assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready && !win_open && !win_close) |=>
            (wb_valid && $stable(wb_index) && $stable(wb_erase)));

    // R6: kind follows the block's mark
    assert_wb_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_erase ? erased_vec[wb_index] : dirty_vec[wb_index]));

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    // R8: close discards every mark
    assert_close_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> (dirty_vec == '0 && erased_vec == '0));

    // R3: rejected request leaves marks alone
    assert_reject_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_ack && !mark_ok && !win_open && !win_close && !busy && !$past(busy)
         && !$past(win_open) && !$past(win_close)) |->
            (dirty_vec == $past(dirty_vec) && erased_vec == $past(erased_vec)));
endmodule

bind wwin_tracker wwin_tracker_chk #(.NBLK(NBLK), .IW(IW)) chk_i (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .win_close(win_close),
    .mark_ack(mark_ack), .mark_ok(mark_ok), .flush_done(flush_done),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_index(wb_index), .wb_erase(wb_erase),
    .busy(busy), .dirty_vec(dirty_vec), .erased_vec(erased_vec)
);

// File: tb/wwin_tracker_tb.sv
module wwin_tracker_tb_top;
    localparam int NBLK = 16;
    localparam int IW   = $clog2(NBLK);
    localparam int CW   = IW + 1;

    logic clk = 0, rst_n = 0;
    logic win_open = 0, win_close = 0;
    logic [CW-1:0] win_blocks = '0;
    logic mark_valid = 0, mark_erase = 0;
    logic [CW-1:0] mark_off = '0, mark_cnt = '0;
    logic mark_ack, mark_ok;
    logic flush_start = 0, flush_done;
    logic wb_valid, wb_ready = 0, wb_erase;
    logic [IW-1:0] wb_index;
    logic [IW-1:0] rd_block = '0;
    logic [7:0] rd_data_in = 8'h5A, rd_data_out;

    int n_chk = 0, n_fail = 0;
    int model [NBLK];
    int exp_q [$];
    int win_sz = 0;
    bit ended = 0;

    wwin_tracker #(.NBLK(NBLK)) dut_i (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // wb_ready pattern, driven away from the sampling edge
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #2 wb_ready = (cyc % 3) != 1;
            cyc++;
        end
    end

    // monitor: pops expected writebacks
    always @(negedge clk) begin
        if (rst_n && wb_valid && wb_ready) begin
            int got;
            got = {wb_erase, 8'(wb_index)};
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected writeback", got, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(got == e, "R6 writeback order/kind", got, e);
            end
        end
    end

    task automatic open_win(input int sz);
        @(negedge clk);
        win_open = 1; win_blocks = CW'(sz);
        @(negedge clk);
        win_open = 0;
        win_sz = sz;
        for (int i = 0; i < NBLK; i++) model[i] = 0;
    endtask

    task automatic close_win();
        @(negedge clk);
        win_close = 1;
        @(negedge clk);
        win_close = 0;
        for (int i = 0; i < NBLK; i++) model[i] = 0;
    endtask

    task automatic do_mark(input bit er, input int off, input int cnt, input bit exp_ok,
                           input string req);
        @(negedge clk);
        mark_valid = 1; mark_erase = er; mark_off = CW'(off); mark_cnt = CW'(cnt);
        @(negedge clk);
        mark_valid = 0;
        chk(mark_ack == 1'b1, req, int'(mark_ack), 1);
        chk(mark_ok == exp_ok, req, int'(mark_ok), int'(exp_ok));
        if (exp_ok)
            for (int i = off; i < off + cnt; i++) model[i] = er ? 2 : 1;
    endtask

    task automatic check_reads(input string req);
        for (int i = 0; i < NBLK; i++) begin
            rd_block = IW'(i);
            rd_data_in = 8'(8'h30 + i);
            #1;
            if (model[i] == 2) chk(rd_data_out == 8'hFF, req, rd_data_out, 8'hFF);
            else chk(rd_data_out == 8'(8'h30 + i), req, rd_data_out, 8'h30 + i);
        end
    endtask

    task automatic do_flush(input string req, input bit try_mark);
        bit seen = 0;
        for (int i = 0; i < NBLK; i++)
            if (model[i] != 0) exp_q.push_back({(model[i] == 2) ? 1'b1 : 1'b0, 8'(i)});
        @(negedge clk);
        flush_start = 1;
        @(negedge clk);
        flush_start = 0;
        if (try_mark) begin
            // R9: mark during flush rejected
            mark_valid = 1; mark_erase = 1; mark_off = 0; mark_cnt = 1;
            @(negedge clk);
            mark_valid = 0;
            chk(mark_ack && !mark_ok, "R9 mark during flush", int'(mark_ok), 0);
            if (flush_done) seen = 1;
        end
        for (int c = 0; c < 300 && !seen; c++) begin
            if (flush_done) seen = 1;
            else @(negedge clk);
        end
        chk(seen, req, int'(seen), 1);
        chk(exp_q.size() == 0, "R6 all writebacks issued", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        chk(flush_done == 1'b0, "R7 done single pulse", int'(flush_done), 0);
        for (int i = 0; i < NBLK; i++) model[i] = 0;
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NBLK; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(mark_ack == 0, "R1 mark_ack", int'(mark_ack), 0);
        chk(wb_valid == 0, "R1 wb_valid", int'(wb_valid), 0);
        chk(flush_done == 0, "R1 flush_done", int'(flush_done), 0);
        check_reads("R1 read passthrough");

        // R9 mark with no window
        do_mark(1, 0, 2, 0, "R9 mark with window closed");
        check_reads("R9 no change when closed");

        open_win(8);
        do_mark(0, 1, 2, 1, "R2 dirty mark accepted");
        do_mark(1, 4, 3, 1, "R2 erased mark accepted");
        check_reads("R5 erased reads FF");
        do_mark(1, 6, 3, 0, "R3 past window end rejected");
        do_mark(1, 7, 1, 1, "R3 exact end accepted");
        check_reads("R3 marks unchanged");
        do_mark(0, 5, 1, 1, "R4 erased then dirty");
        do_mark(1, 2, 1, 1, "R4 dirty then erased");
        check_reads("R4 latest mark wins");
        do_flush("R7 flush completes", 0);
        check_reads("R7 marks cleared after flush");
        do_flush("R7 empty flush completes", 0);

        do_mark(0, 0, 8, 1, "R2 full window dirty");
        do_flush("R7 flush with mark attempt", 1);

        do_mark(1, 0, 4, 1, "R2 erased before close");
        close_win();
        check_reads("R8 close discards erased");
        do_flush("R8 nothing left after close", 0);

        open_win(0);
        do_mark(0, 0, 0, 0, "R3 zero size rejects");
        do_mark(0, 0, 1, 0, "R3 zero size rejects count1");

        open_win(16);
        do_mark(0, 15, 2, 0, "R3 off15 cnt2 rejected");
        do_mark(0, 15, 1, 1, "R2 last block");
        do_mark(1, 0, 2, 1, "R2 first blocks erased");
        do_mark(0, 9, 3, 1, "R2 middle dirty");
        check_reads("R5 second window reads");
        open_win(16);
        check_reads("R8 reopen discards marks");
        do_mark(1, 3, 2, 1, "R2 erase after reopen");
        do_mark(0, 12, 4, 1, "R2 dirty tail");
        do_flush("R6 mixed flush", 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule